// File: doc/BRIEF.md
# Domain Permission Checker

This block sits behind an address translator and decides, for every translated access, whether the requesting master may perform it. The page entry that the translator found carries a 4-bit domain index. That index selects one of sixteen access-control domains. For each master, each domain holds one bit that blocks reads and one bit that blocks writes. The checker answers allow or deny one cycle after the access is presented.

When an access is denied, the checker raises that master's fault status bit. If the bit was clear, it also records the faulting address and the full entry word in that master's capture registers. A fault interrupt is raised whenever a status bit is set and its enable bit is set. Software programs the domains, enables and clears through a simple word-addressed register port with a combinational read.

Top module: `dpc_domain_guard`

## Requirements
- R1: After reset, the register at 0x0B0 reads 0x00000AAA. This is domain 0, with the write-block bit set for all six masters, so domain 0 allows reads only. Every other domain field, the status at 0x108, the enable at 0x100 and all capture registers read 0, and `irq` is low.
- R2: The 16-bit field of domain d lives in the register at 0x0B0 + (d/2)*4. Even domains use bits 15:0 and odd domains use bits 31:16. In each field, bits 11:0 are stored and read back, and bits 15:12 read as 0.
- R3: For an access with `acc_valid` high, the domain is `acc_entry[7:4]`. The access is denied exactly when the domain field has bit 2*m set (read, `acc_write`=0) or bit 2*m+1 set (write, `acc_write`=1), where m is `acc_master`. `resp_valid` and `resp_deny` show the result on the cycle after the access and are low when no access was presented.
- R4: An access from master ID 6 or 7 is always denied and changes no status bit and no capture register.
- R5: A denied access from master m (0 to 5) sets bit m of the status register at 0x108 (bits 5:0).
- R6: A denial from master m while status bit m is clear loads `acc_addr` into 0x110 + 4*m and `acc_entry` into 0x150 + 4*m. While status bit m stays set, later denials from master m leave both registers unchanged.
- R7: Writing ones to 0x104 clears the matching status bits, and 0x104 reads as 0. A denial for master m in the same cycle as a clear of bit m leaves the bit set and captures the new address and entry.
- R8: `irq` is high exactly when some status bit is set whose enable bit is also set. The enable register is at 0x100, bits 5:0, and reads back.
- R9: An allowed access changes no status bit and no capture register.
- R10: A domain register write takes effect for accesses presented from the next cycle on. An access in the same cycle as the write is judged with the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for a write or a read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| acc_valid | input | 1 | A translated access is presented |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| acc_master | input | 3 | Requesting master ID |
| acc_addr | input | 32 | Faulting address to record on denial |
| acc_entry | input | 32 | Page entry word; bits 7:4 hold the domain index |
| resp_valid | output | 1 | Result of the previous cycle's access is valid |
| resp_deny | output | 1 | Previous cycle's access was denied |
| irq | output | 1 | Fault interrupt |

## Verification
Directed accesses first cover the default read-only domain and then hand-programmed read-only, write-only and fully blocked domains. This shows that the direction bit selects the read-block or the write-block position. Masters 6 and 7 are applied to separate the out-of-range deny path from normal status capture. Back-to-back denials, a clear alone and a clear in the same cycle as a new denial separate the first-fault hold from re-arming. A register write in the same cycle as an access shows whether the old or the new permission is used. A long pseudo-random run then mixes masters, domains, directions, enables, clears and domain rewrites. A behavioural model checks it every cycle, which exercises interactions the directed cases do not reach.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int REG_AW        = 12;
  localparam int DOM_HALF_W    = 16;
  localparam int ENTRY_DOM_LSB = 4;
  localparam int DOM_IDX_W     = 4;

  localparam logic [REG_AW-1:0] OFS_DOM_BASE = 12'h0B0;
  localparam logic [REG_AW-1:0] OFS_IRQ_EN   = 12'h100;
  localparam logic [REG_AW-1:0] OFS_IRQ_CLR  = 12'h104;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 12'h108;
  localparam logic [REG_AW-1:0] OFS_FLT_ADDR = 12'h110;
  localparam logic [REG_AW-1:0] OFS_FLT_DATA = 12'h150;

  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/dpc_domain_regs.sv
module dpc_domain_regs
  import dpc_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int NUM_DOMAINS = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [REG_AW-1:0]                          wr_addr,
  input  logic [31:0]                                wr_data,
  output logic [NUM_DOMAINS-1:0][2*NUM_MASTERS-1:0]  blk_o
);
  localparam int FW = 2*NUM_MASTERS;
  // default domain: write-block set for every master, reads open
  localparam logic [FW-1:0] DOM0_RST = {NUM_MASTERS{2'b10}};

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    localparam int PAIR = d / 2;
    localparam int LSB  = (d % 2) * DOM_HALF_W;
    localparam logic [FW-1:0] RST_VAL = (d == 0) ? DOM0_RST : {FW{1'b0}};

    logic          hit;
    logic [FW-1:0] fld_d;
    logic [FW-1:0] fld_q;

    always_comb begin
      hit   = wr_en && (wr_addr == REG_AW'(int'(OFS_DOM_BASE) + 4*PAIR));
      fld_d = wr_data[LSB +: FW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q <= RST_VAL;
      end else if (hit) begin
        fld_q <= fld_d;
      end
    end

    assign blk_o[d] = fld_q;
  end
endmodule

// File: rtl/dpc_check.sv
module dpc_check
  import dpc_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int NUM_DOMAINS = 16,
  parameter int MST_W       = 3
) (
  input  logic [NUM_DOMAINS-1:0][2*NUM_MASTERS-1:0] blk_i,
  input  logic [MST_W-1:0]                          master_i,
  input  acc_dir_e                                  dir_i,
  input  logic [DOM_IDX_W-1:0]                      dom_i,
  output logic                                      deny_o,
  output logic [NUM_MASTERS-1:0]                    hit_oh_o
);
  logic [2*NUM_MASTERS-1:0] row;
  logic                     known;
  logic [MST_W:0]           sel;

  always_comb begin
    row    = blk_i[dom_i];
    known  = (master_i < MST_W'(NUM_MASTERS));
    sel    = {master_i, logic'(dir_i)};
    deny_o = 1'b1;
    if (known) begin
      deny_o = row[sel];
    end
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_oh
    assign hit_oh_o[m] = (master_i == MST_W'(m));
  end
endmodule

// File: rtl/dpc_fault_slot.sv
module dpc_fault_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       entry_i,
  output logic              stat_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       data_o
);
  logic              stat_q;
  logic              stat_d;
  logic              held;
  logic              cap;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;

  always_comb begin
    held   = stat_q & ~clr_i;
    cap    = set_i & ~held;
    stat_d = held | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap) begin
      addr_q <= addr_i;
      data_q <= entry_i;
    end
  end

  assign stat_o = stat_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/dpc_domain_guard.sv
module dpc_domain_guard
  import dpc_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int NUM_DOMAINS = 16,
  parameter int MST_W       = 3,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [MST_W-1:0]  acc_master,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_entry,
  output logic              resp_valid,
  output logic              resp_deny,
  output logic              irq
);
  localparam int NUM_PAIRS = NUM_DOMAINS / 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_DOMAINS-1:0][2*NUM_MASTERS-1:0] blk;
  logic                                      deny;
  logic [NUM_MASTERS-1:0]                    hit_oh;
  logic [DOM_IDX_W-1:0]                      dom_idx;

  assign dom_idx = acc_entry[ENTRY_DOM_LSB +: DOM_IDX_W];

  dpc_domain_regs #(
    .NUM_MASTERS (NUM_MASTERS),
    .NUM_DOMAINS (NUM_DOMAINS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_we),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .blk_o   (blk)
  );

  dpc_check #(
    .NUM_MASTERS (NUM_MASTERS),
    .NUM_DOMAINS (NUM_DOMAINS),
    .MST_W       (MST_W)
  ) u_check (
    .blk_i    (blk),
    .master_i (acc_master),
    .dir_i    (acc_dir_e'(acc_write)),
    .dom_i    (dom_idx),
    .deny_o   (deny),
    .hit_oh_o (hit_oh)
  );

  // interrupt enable
  logic                   en_hit;
  logic [NUM_MASTERS-1:0] en_d;
  logic [NUM_MASTERS-1:0] irq_en_q;

  always_comb begin
    en_hit = reg_we && (reg_addr == OFS_IRQ_EN);
    en_d   = reg_wdata[NUM_MASTERS-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_en_q <= '0;
    end else if (en_hit) begin
      irq_en_q <= en_d;
    end
  end

  // per-master fault capture
  logic [NUM_MASTERS-1:0]             clr_vec;
  logic [NUM_MASTERS-1:0]             set_vec;
  logic [NUM_MASTERS-1:0]             stat_vec;
  logic [NUM_MASTERS-1:0][ADDR_W-1:0] fault_addr_vec;
  logic [NUM_MASTERS-1:0][31:0]       fault_data_vec;

  always_comb begin
    clr_vec = '0;
    if (reg_we && (reg_addr == OFS_IRQ_CLR)) begin
      clr_vec = reg_wdata[NUM_MASTERS-1:0];
    end
    set_vec = (acc_valid && deny) ? hit_oh : '0;
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_slot
    dpc_fault_slot #(
      .ADDR_W (ADDR_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_i   (set_vec[m]),
      .clr_i   (clr_vec[m]),
      .addr_i  (acc_addr),
      .entry_i (acc_entry),
      .stat_o  (stat_vec[m]),
      .addr_o  (fault_addr_vec[m]),
      .data_o  (fault_data_vec[m])
    );
  end

  // response
  logic rv_d;
  logic rd_d;
  logic rv_q;
  logic rd_q;

  always_comb begin
    rv_d = acc_valid;
    rd_d = acc_valid & deny;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rv_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      rd_q <= rd_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_deny  = rd_q;
  assign irq        = |(stat_vec & irq_en_q);

  // register read
  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (reg_addr == REG_AW'(int'(OFS_DOM_BASE) + 4*p)) begin
        reg_rdata[DOM_HALF_W-1:0]            = DOM_HALF_W'(blk[2*p]);
        reg_rdata[2*DOM_HALF_W-1:DOM_HALF_W] = DOM_HALF_W'(blk[2*p+1]);
      end
    end
    if (reg_addr == OFS_IRQ_EN) begin
      reg_rdata = 32'(irq_en_q);
    end
    if (reg_addr == OFS_STATUS) begin
      reg_rdata = 32'(stat_vec);
    end
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (reg_addr == REG_AW'(int'(OFS_FLT_ADDR) + 4*m)) begin
        reg_rdata = 32'(fault_addr_vec[m]);
      end
      if (reg_addr == REG_AW'(int'(OFS_FLT_DATA) + 4*m)) begin
        reg_rdata = fault_data_vec[m];
      end
    end
  end
endmodule

// File: rtl/dpc_domain_guard_chk.sv
module dpc_domain_guard_chk
  import dpc_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int MST_W       = 3,
  parameter int ADDR_W      = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             reg_we,
  input logic [REG_AW-1:0]                reg_addr,
  input logic [31:0]                      reg_wdata,
  input logic                             acc_valid,
  input logic [MST_W-1:0]                 acc_master,
  input logic                             resp_valid,
  input logic                             resp_deny,
  input logic                             irq,
  input logic [NUM_MASTERS-1:0]           stat,
  input logic [NUM_MASTERS-1:0]           en,
  input logic [NUM_MASTERS-1:0][ADDR_W-1:0] faddr
);
  a_r3_resp_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);

  a_r3_no_resp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!resp_valid && !resp_deny));

  a_r4_bad_master_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_master >= MST_W'(NUM_MASTERS)) &&
     !(reg_we && (reg_addr == OFS_IRQ_CLR)))
    |=> (resp_deny && $stable(stat)));

  a_r5_deny_marks_master: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_master < MST_W'(NUM_MASTERS)))
    |=> (!resp_deny || stat[$past(acc_master)]));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat != '0) && (en != '0)));

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
    a_r6_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[m] && !(reg_we && (reg_addr == OFS_IRQ_CLR) && reg_wdata[m]))
      |=> $stable(faddr[m]));

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (reg_addr == OFS_IRQ_CLR) && reg_wdata[m] &&
       !(acc_valid && (acc_master == MST_W'(m))))
      |=> !stat[m]);
  end
endmodule

bind dpc_domain_guard dpc_domain_guard_chk #(
  .NUM_MASTERS (NUM_MASTERS),
  .MST_W       (MST_W),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .acc_valid  (acc_valid),
  .acc_master (acc_master),
  .resp_valid (resp_valid),
  .resp_deny  (resp_deny),
  .irq        (irq),
  .stat       (stat_vec),
  .en         (irq_en_q),
  .faddr      (fault_addr_vec)
);

// File: tb/dpc_domain_guard_tb.sv
module dpc_domain_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_master = '0;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_entry = '0;
  logic        resp_valid;
  logic        resp_deny;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  dpc_domain_guard u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_master(acc_master), .acc_addr(acc_addr),
    .acc_entry(acc_entry), .resp_valid(resp_valid), .resp_deny(resp_deny),
    .irq(irq)
  );

  // behavioural reference
  logic [11:0] m_blk [16];
  logic [5:0]  m_st;
  logic [5:0]  m_en;
  logic [31:0] m_fa [6];
  logic [31:0] m_fd [6];
  logic        e_rv;
  logic        e_rd;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [11:0] addr_pick(int k);
    if (k < 8)  return 12'(12'h0B0 + 4*k);
    if (k == 8) return 12'h100;
    if (k == 9) return 12'h104;
    if (k == 10) return 12'h108;
    if (k < 17) return 12'(12'h110 + 4*(k-11));
    if (k < 23) return 12'(12'h150 + 4*(k-17));
    return 12'h1F0;
  endfunction

  function automatic logic [31:0] ent(int dom, logic [31:0] hi);
    return (hi & ~32'h0000_00F0) | 32'(dom << 4);
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    for (int i = 0; i < 8; i++)
      if (a == 12'(12'h0B0 + 4*i)) return {4'h0, m_blk[2*i+1], 4'h0, m_blk[2*i]};
    if (a == 12'h100) return 32'(m_en);
    if (a == 12'h108) return 32'(m_st);
    for (int i = 0; i < 6; i++) begin
      if (a == 12'(12'h110 + 4*i)) return m_fa[i];
      if (a == 12'(12'h150 + 4*i)) return m_fd[i];
    end
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_blk[i] = 12'h000;
    m_blk[0] = 12'hAAA;
    for (int i = 0; i < 6; i++) begin m_fa[i] = '0; m_fd[i] = '0; end
    m_st = '0; m_en = '0; e_rv = 0; e_rd = 0;
  endtask

  task automatic model_clock();
    logic [5:0] held;
    logic d;
    int mi;
    d = 1'b0;
    mi = int'(acc_master);
    if (acc_valid) begin
      if (mi > 5) d = 1'b1;
      else d = m_blk[int'(acc_entry[7:4])][2*mi + int'(acc_write)];
    end
    e_rv = acc_valid;
    e_rd = d;
    held = m_st;
    if (reg_we && reg_addr == 12'h104) held = held & ~reg_wdata[5:0];
    if (d && mi < 6) begin
      if (!held[mi]) begin m_fa[mi] = acc_addr; m_fd[mi] = acc_entry; end
      held[mi] = 1'b1;
    end
    m_st = held;
    if (reg_we) begin
      for (int i = 0; i < 8; i++)
        if (reg_addr == 12'(12'h0B0 + 4*i)) begin
          m_blk[2*i]   = reg_wdata[11:0];
          m_blk[2*i+1] = reg_wdata[27:16];
        end
      if (reg_addr == 12'h100) m_en = reg_wdata[5:0];
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic we, logic [11:0] a, logic [31:0] wd, logic av, logic aw,
                      logic [2:0] am, logic [31:0] aa, logic [31:0] ae, string tag);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    acc_valid = av; acc_write = aw; acc_master = am; acc_addr = aa; acc_entry = ae;
    #1ns;
    chk(tag, "reg_rdata", reg_rdata, m_read(a));
    @(posedge clk);
    model_clock();
    @(negedge clk);
    chk(tag, "resp_valid", 32'(resp_valid), 32'(e_rv));
    chk(tag, "resp_deny", 32'(resp_deny), 32'(e_rd));
    chk(tag, "irq", 32'(irq), 32'(|(m_st & m_en)));
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(1'b0, a, 32'h0, 1'b0, 1'b0, 3'd0, 32'h0, 32'h0, tag);
  endtask

  task automatic acc(logic aw, logic [2:0] am, logic [31:0] aa, logic [31:0] ae, string tag);
    step(1'b0, 12'h108, 32'h0, 1'b1, aw, am, aa, ae, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] wd, string tag);
    step(1'b1, a, wd, 1'b0, 1'b0, 3'd0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R3: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents of every register
    for (int k = 0; k < 24; k++) rd(addr_pick(k), "R1");

    // R3 default domain: reads pass, writes fail
    acc(1'b0, 3'd0, 32'h1000_0000, ent(0, 32'h0000_1002), "R3");
    acc(1'b1, 3'd2, 32'h2222_0040, ent(0, 32'hABCD_E002), "R3");
    rd(12'h108, "R5");
    rd(12'h118, "R6");
    rd(12'h158, "R6");
    // R6: second denial keeps the first capture
    acc(1'b1, 3'd2, 32'h3333_0000, ent(0, 32'h5555_0002), "R6");
    rd(12'h118, "R6");
    rd(12'h158, "R6");

    // R2: domain fields, upper nibble of each half not stored
    wr(12'h0B4, 32'hF555_FAAA, "R2");
    rd(12'h0B4, "R2");
    wr(12'h0B0, 32'h0FFF_0AAA, "R2");
    rd(12'h0B0, "R2");

    // R3: direction selects the block bit
    acc(1'b0, 3'd1, 32'h0100_0000, ent(2, 32'h0), "R3");
    acc(1'b1, 3'd1, 32'h0100_1000, ent(2, 32'h0), "R3");
    acc(1'b0, 3'd4, 32'h0400_0000, ent(3, 32'h0), "R3");
    acc(1'b1, 3'd4, 32'h0400_1000, ent(3, 32'h0), "R3");
    acc(1'b0, 3'd0, 32'h0000_2000, ent(1, 32'h0), "R3");
    acc(1'b1, 3'd5, 32'h0500_0000, ent(9, 32'h0), "R3");

    // R9: allowed access leaves status and captures alone
    acc(1'b0, 3'd3, 32'h0300_0000, ent(7, 32'h0), "R9");
    rd(12'h108, "R9");
    rd(12'h11C, "R9");

    // R4: unknown masters
    acc(1'b1, 3'd6, 32'h0600_0000, ent(7, 32'h0), "R4");
    acc(1'b0, 3'd7, 32'h0700_0000, ent(5, 32'h0), "R4");
    rd(12'h108, "R4");

    // R10: same-cycle write uses old permissions
    step(1'b1, 12'h0B8, 32'h0000_0FFF, 1'b1, 1'b0, 3'd1, 32'h0A00_0000, ent(4, 32'h0), "R10");
    acc(1'b0, 3'd1, 32'h0B00_0000, ent(4, 32'h0), "R10");

    // R7: clear
    wr(12'h104, 32'h0000_003F, "R7");
    rd(12'h108, "R7");
    rd(12'h104, "R7");

    // R8: enable gating
    acc(1'b1, 3'd2, 32'h2000_0000, ent(0, 32'h0), "R8");
    wr(12'h100, 32'h0000_003B, "R8");
    rd(12'h100, "R8");
    wr(12'h100, 32'h0000_0004, "R8");
    rd(12'h100, "R8");

    // R7: clear and new denial in one cycle
    step(1'b1, 12'h104, 32'h0000_0004, 1'b1, 1'b1, 3'd2, 32'h5555_0000, ent(0, 32'h7700_0000), "R7");
    rd(12'h108, "R7");
    rd(12'h118, "R7");
    rd(12'h158, "R7");

    // R3: mixed pseudo-random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      logic [31:0] r2;
      r  = rnd();
      r2 = rnd();
      step(r[9:6] == 4'd0, addr_pick(int'(r[20:16]) % 24), rnd(),
           r[0] | r[1], r[5], r[4:2], r2, rnd(), "R3");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule